// File: doc/BRIEF.md
# Trail Trace Identifier Transmitter

This block keeps a sixteen-byte trail trace identifier and turns it into a serial overhead bit stream. The stream carries one identifier byte per multiframe slot, and the sixteen bytes repeat in a fixed cycle. An external framer drives the serializer. A one-cycle bit strobe moves the output on by one bit. A separate start strobe pulls the sequence back to byte 0 so that it stays aligned with the framer's multiframe.

Software reaches the block through a small 16-bit register port with three locations:

- **Control word.** Holds four mode bits.
- **Byte pointer.** Selects a storage location.
- **Data port.** Writes or reads the byte the pointer selects.

The four modes work as follows:

- **Alignment marking.** The first transmitted bit of every byte can be replaced by a multiframe alignment mark.
- **Bit order.** Each byte can be sent MSB first or LSB first.
- **Idle.** The stored identifier can be replaced by all-zero bytes.
- **Inversion.** The final serial output can be inverted.

The byte contents and the mode bits are captured at the start of each byte. The byte being shifted out is never altered part way through.

Top module: `trace_id_tx`

## Requirements
- R1: Register offsets are 0xE8 (control), 0xEA (byte pointer) and 0xEC (data port). `reg_rdata` is registered and shows the location addressed by `reg_addr` one clock later. Offset 0xEE and every other offset read as zero.
- R2: The control word resets to zero. Only bits [3:0] can be written, and bits [15:4] always read as zero. The field layout is:
  - bit 3: alignment-marking disable
  - bit 2: idle
  - bit 1: invert
  - bit 0: LSB-first
- R3: The byte pointer keeps the low 4 bits of the written value and reads them back in [3:0]. A data-port write stores `reg_wdata[7:0]` at the pointed location. A data-port read returns that byte in [7:0], with zeros above it.
- R4: With control bit 0 clear, bit 7 of each byte is sent first. With control bit 0 set, bit 0 is sent first.
- R5: With control bit 3 clear, the first transmitted bit of each byte is replaced by the alignment mark. The mark is 1 for byte 0 and 0 for bytes 1 to 15. With control bit 3 set, the byte is sent unchanged.
- R6: With control bit 2 set, all-zero bytes are sent in place of the stored bytes. Alignment marking still applies to these zero bytes.
- R7: With control bit 1 set, every output bit is inverted after all other processing.
- R8: `ser_out` resets to 0 and changes only on the clock edge that samples `bit_stb` high. In every other cycle it holds its value.
- R9: The bytes are sent in the order 0 to 15 and then wrap to 0. The start strobe works in two ways:
  - `byte_stb` on its own makes the next bit strobe begin byte 0.
  - `byte_stb` together with `bit_stb` makes that strobe carry the first bit of byte 0.
- R10: The stored byte and all four control bits are captured at the first bit of each byte. Register writes made while a byte is being sent affect only later bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write enable |
| reg_rdata | output | 16 | Registered read data |
| bit_stb | input | 1 | One-cycle strobe that advances the serializer by one bit |
| byte_stb | input | 1 | Start strobe that realigns the sequence to byte 0 |
| ser_out | output | 1 | Serial trail trace bit |

## Verification
- **Read data.** `reg_rdata` is due one clock after `reg_addr` is presented. The bench sets the offset on a falling edge and compares on the next falling edge.
- **Serial output.** A serial bit is due on the rising edge that samples `bit_stb`. The bench raises the strobe for exactly one cycle and compares `ser_out` on the falling edge that follows.
- **Writes during a byte.** A storage or control write becomes visible only at the next byte's first bit. The bench reference model copies the identifier and the control bits at the same point in its own sequence count.
- **Hold behaviour.** Idle gaps of several cycles are placed between strobes, and the output is checked to be unchanged across them.

// File: rtl/trace_tx_pkg.sv
package trace_tx_pkg;
  localparam logic [7:0] OFF_CTRL = 8'hE8;
  localparam logic [7:0] OFF_PTR  = 8'hEA;
  localparam logic [7:0] OFF_DATA = 8'hEC;
  localparam logic [7:0] OFF_NONE = 8'hEE;

  typedef struct packed {
    logic mark_dis;
    logic idle;
    logic inv;
    logic lsb_first;
  } tt_ctl_t;
endpackage

// File: rtl/trace_store.sv
module trace_store #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [BYTE_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [BYTE_W-1:0] rdata_b
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/trace_regs.sv
module trace_regs
  import trace_tx_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [BYTE_W-1:0] ptr_byte,
  output tt_ctl_t           ctl,
  output logic [IDX_W-1:0]  ptr,
  output logic              st_we,
  output logic [BYTE_W-1:0] st_wdata
);
  localparam int CTL_W = $bits(tt_ctl_t);

  logic [REG_W-1:0] rd_next;

  assign st_we    = reg_we && (reg_addr == OFF_DATA);
  assign st_wdata = reg_wdata[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
      ptr <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFF_CTRL) ctl <= tt_ctl_t'(reg_wdata[CTL_W-1:0]);
      if (reg_addr == OFF_PTR)  ptr <= reg_wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      OFF_CTRL: rd_next[CTL_W-1:0]  = ctl;
      OFF_PTR:  rd_next[IDX_W-1:0]  = ptr;
      OFF_DATA: rd_next[BYTE_W-1:0] = ptr_byte;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R2: control word clears on reset
  p_ctl_reset_r2: assert property (@(posedge clk) rst |=> (ctl == '0));
  // R1: unused offset reads zero
  p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFF_NONE) |=> (reg_rdata == '0));
  // R2: reserved control bits read zero
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == OFF_CTRL) |=> (reg_rdata[REG_W-1:CTL_W] == '0));
endmodule

// File: rtl/trace_ser.sv
module trace_ser
  import trace_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_stb,
  input  logic              byte_stb,
  input  tt_ctl_t           ctl,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              ser_out
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;
  logic              inv_q;

  logic [IDX_W-1:0]  idx_sel;
  logic              load;
  logic [BYTE_W-1:0] base;
  logic [BYTE_W-1:0] flipped;
  logic [BYTE_W-1:0] ordered;

  assign idx_sel = byte_stb ? '0 : byte_idx;
  assign rd_idx  = idx_sel;
  assign load    = bit_stb && (byte_stb || (bit_cnt == '0));
  assign base    = ctl.idle ? '0 : rd_byte;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
    assign flipped[i] = base[BYTE_W-1-i];
  end

  always_comb begin
    ordered = ctl.lsb_first ? flipped : base;
    if (!ctl.mark_dis) ordered[BYTE_W-1] = (idx_sel == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      inv_q    <= 1'b0;
      ser_out  <= 1'b0;
    end else if (bit_stb) begin
      if (load) begin
        ser_out  <= ordered[BYTE_W-1] ^ ctl.inv;
        shreg    <= ordered << 1;
        inv_q    <= ctl.inv;
        bit_cnt  <= CNT_W'(1);
        byte_idx <= idx_sel;
      end else begin
        ser_out <= shreg[BYTE_W-1] ^ inv_q;
        shreg   <= shreg << 1;
        if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
          bit_cnt  <= '0;
          byte_idx <= (byte_idx == IDX_W'(DEPTH - 1)) ? '0 : byte_idx + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end else if (byte_stb) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
    end
  end

  // R8: output holds without a bit strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_stb |=> $stable(ser_out));
  // R9: lone start strobe realigns to byte 0, bit 0
  p_realign_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_stb && !bit_stb) |=> (bit_cnt == '0 && byte_idx == '0));
  // R5: byte 0 begins with a set mark when marking is on and not inverted
  p_mark_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && byte_stb && !ctl.mark_dis && !ctl.inv) |=> ser_out);
  // R6: idle with marking off and no inversion sends zero first
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && byte_stb && ctl.idle && ctl.mark_dis && !ctl.inv) |=> !ser_out);
endmodule

// File: rtl/trace_id_tx.sv
module trace_id_tx
  import trace_tx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              bit_stb,
  input  logic              byte_stb,
  output logic              ser_out
);
  localparam int IDX_W = $clog2(DEPTH);

  tt_ctl_t           ctl;
  logic [IDX_W-1:0]  ptr;
  logic              st_we;
  logic [BYTE_W-1:0] st_wdata;
  logic [BYTE_W-1:0] ptr_byte;
  logic [IDX_W-1:0]  ser_idx;
  logic [BYTE_W-1:0] ser_byte;

  trace_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ptr_byte(ptr_byte),
    .ctl(ctl), .ptr(ptr), .st_we(st_we), .st_wdata(st_wdata)
  );

  trace_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .we(st_we), .waddr(ptr), .wdata(st_wdata),
    .raddr_a(ptr), .rdata_a(ptr_byte),
    .raddr_b(ser_idx), .rdata_b(ser_byte)
  );

  trace_ser #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_ser (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .byte_stb(byte_stb),
    .ctl(ctl), .rd_idx(ser_idx), .rd_byte(ser_byte), .ser_out(ser_out)
  );
endmodule

// File: tb/sim_trace_id_tx.sv
module sim_trace_id_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic        bit_stb = 1'b0;
  logic        byte_stb = 1'b0;
  logic        ser_out;

  int n_chk = 0;
  int n_bad = 0;

  // bench reference state
  logic [7:0] mem_m [16];
  logic [3:0] ctl_m = 4'h0;
  int         m_cnt = 0;
  int         m_idx = 0;
  logic [7:0] m_sh = 8'h0;
  logic       m_inv = 1'b0;
  logic       last_out = 1'b0;

  always #5 clk = ~clk;

  trace_id_tx u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .bit_stb(bit_stb),
    .byte_stb(byte_stb), .ser_out(ser_out)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 8'hE8) ctl_m = d[3:0];
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic put_byte(int idx, logic [7:0] v);
    wr(8'hEA, 16'(idx));
    wr(8'hEC, {8'h00, v});
    mem_m[idx] = v;
  endtask

  // next expected bit from requirements R4..R7, R9, R10
  function automatic logic model_bit(bit start);
    logic [7:0] b;
    logic o;
    if (start) begin m_cnt = 0; m_idx = 0; end
    if (m_cnt == 0) begin
      b = ctl_m[2] ? 8'h00 : mem_m[m_idx];
      if (ctl_m[0]) b = {<<{b}};
      if (!ctl_m[3]) b[7] = (m_idx == 0);
      m_sh = b;
      m_inv = ctl_m[1];
    end
    o = m_sh[7] ^ m_inv;
    m_sh = m_sh << 1;
    m_cnt++;
    if (m_cnt == 8) begin m_cnt = 0; m_idx = (m_idx + 1) % 16; end
    return o;
  endfunction

  task automatic strobe(string req, bit start);
    logic e;
    e = model_bit(start);
    @(negedge clk);
    bit_stb = 1'b1; byte_stb = start;
    @(negedge clk);
    bit_stb = 1'b0; byte_stb = 1'b0;
    check(req, {15'h0, ser_out}, {15'h0, e});
    last_out = ser_out;
  endtask

  task automatic realign();
    @(negedge clk);
    byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
    m_cnt = 0; m_idx = 0;
  endtask

  task automatic t_reset();
    check("R8 reset ser_out", {15'h0, ser_out}, 16'h0);
    rd_chk("R2 control reset", 8'hE8, 16'h0000);
    rd_chk("R3 pointer reset", 8'hEA, 16'h0000);
  endtask

  task automatic t_regs();
    wr(8'hE8, 16'hFFF5);
    rd_chk("R2 reserved bits zero", 8'hE8, 16'h0005);
    wr(8'hEA, 16'hABC7);
    rd_chk("R3 pointer low nibble", 8'hEA, 16'h0007);
    wr(8'hEC, 16'h1234);
    mem_m[7] = 8'h34;
    rd_chk("R3 data readback", 8'hEC, 16'h0034);
    rd_chk("R1 unused offset", 8'hEE, 16'h0000);
    rd_chk("R1 other offset", 8'h10, 16'h0000);
    wr(8'hE8, 16'h0000);
  endtask

  task automatic t_all_modes();
    for (int c = 0; c < 16; c++) begin
      wr(8'hE8, 16'(c));
      realign();
      for (int k = 0; k < 128; k++) strobe("R4/R5/R6/R7/R9 mode sweep", 1'b0);
    end
  endtask

  task automatic t_hold();
    wr(8'hE8, 16'h0000);
    realign();
    strobe("R8 strobed bit", 1'b0);
    repeat (5) @(negedge clk);
    check("R8 hold without strobe", {15'h0, ser_out}, {15'h0, last_out});
  endtask

  task automatic t_start_with_bit();
    wr(8'hE8, 16'h0000);
    realign();
    for (int k = 0; k < 13; k++) strobe("R9 advance", 1'b0);
    strobe("R9 start with bit strobe", 1'b1);
    for (int k = 0; k < 9; k++) strobe("R9 after start", 1'b0);
    realign();
    for (int k = 0; k < 8; k++) strobe("R9 lone start", 1'b0);
  endtask

  task automatic t_in_flight();
    wr(8'hE8, 16'h0008);
    realign();
    strobe("R10 first bit", 1'b0);
    strobe("R10 second bit", 1'b0);
    wr(8'hEA, 16'h0000);
    wr(8'hEC, 16'h00C3);
    mem_m[0] = 8'hC3;
    wr(8'hE8, 16'h0003);
    for (int k = 0; k < 6; k++) strobe("R10 byte in flight", 1'b0);
    for (int k = 0; k < 120; k++) strobe("R10 later bytes", 1'b0);
    for (int k = 0; k < 8; k++) strobe("R10 rewritten byte", 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    for (int i = 0; i < 16; i++) put_byte(i, 8'((i * 37 + 11) ^ (i << 4)));
    t_regs();
    t_all_modes();
    t_hold();
    t_start_with_bit();
    t_in_flight();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule